// File: doc/BRIEF.md
# Protected Register Write Unlock

This block holds two control registers that guard against stray stores, plus a status register with a sticky error flag. A protected register only accepts new data when the write arrives as the very next bus access after a write to a dedicated command register. The value written to the command register does not matter. A protected write made without that preceding unlock is dropped, and the error flag is raised.

Reads need no sequence. Reading a protected register leaves the unlock in place. Read-modify-write bit operations are marked by a lock flag. The read half and the write half of such a locked pair count as one access, so a bit set, clear or invert follows the same rule as a plain store.

The two protected values leave the block on dedicated output ports, where clock and power logic can use them. Software drives the bus port with address, write strobe, read strobe and 8-bit data. Read data is combinational during the read cycle.

Top module: `prot_unlock_regs`

## Requirements
- R1: After reset, protected register A holds RST_A (default 0x03), protected register B holds RST_B (default 0xA5), the error flag is 0 and the block is not armed.
- R2: A write of any data to the command register (address 0) arms the block. A read of address 0 returns 0x00.
- R3: A write to protected register A (address 1) or B (address 2) while armed stores the write data in the next cycle. It is visible on the read port and on ctrl_a or ctrl_b.
- R4: A write to a protected register while not armed leaves the register unchanged and sets the error flag, which is bit 0 of the status register (address 3).
- R5: Any read of address 0 or 3 without lock, or any write to address 3, clears the armed state. A protected write that follows such an access is dropped and raises the error flag.
- R6: A read of a protected register returns its value and leaves the armed state unchanged.
- R7: A read with lock high leaves the armed state unchanged. So a locked read followed by a locked write to a protected register commits when armed beforehand, and fails with an error when not armed.
- R8: The error flag stays set until a status write with bit 0 equal to 0. A status write with bit 0 equal to 1 leaves the flag as it was. Status bits 7:1 read as 0.
- R9: A second command write while armed keeps the block armed and raises no error.
- R10: A protected write consumes the armed state whether it is accepted or not. A second protected write right after a successful one is dropped and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 command, 1 protected A, 2 protected B, 3 status |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| lock | input | 1 | Marks both halves of a read-modify-write bit operation |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high, 0 otherwise |
| ctrl_a | output | 8 | Current value of protected register A |
| ctrl_b | output | 8 | Current value of protected register B |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that a locked read is followed by its locked write with only idle cycles in between. The bench issues each access as a single cycle with one strobe high and returns both strobes to 0 afterwards. Idle cycles are not bus accesses and do not touch the armed state, so the bench may place them anywhere. The cases that disarm the block are driven on purpose in the gap between a command write and a protected write: status reads, status writes and command reads.

// File: rtl/prot_pkg.sv
`timescale 1ns/1ps
package prot_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int NUM_PROT = 2;

    localparam logic [ADDR_W-1:0] ADR_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_BASE = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_STAT = 2'd3;

    function automatic logic is_prot(input logic [ADDR_W-1:0] a);
        return (a >= ADR_BASE) && (a < ADR_BASE + ADDR_W'(NUM_PROT));
    endfunction
endpackage

// File: rtl/prot_arm.sv
`timescale 1ns/1ps
module prot_arm
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              lock,
    output logic              armed
);
    typedef struct packed {
        logic armed;
    } arm_t;

    arm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            // every write ends the window; only a command write opens it again
            st_d.armed = (addr == ADR_CMD);
        end else if (rd_en) begin
            if (!(lock || is_prot(addr))) begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;

    AST_CMD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_CMD) |=> armed); // R2
    AST_PROT_WR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_prot(addr)) |=> !armed); // R10
    AST_PROT_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && is_prot(addr)) |=> $stable(armed)); // R6
    AST_LOCK_RD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && lock) |=> $stable(armed)); // R7
    AST_STAT_WR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_STAT) |=> !armed); // R5
endmodule

// File: rtl/prot_reg.sv
`timescale 1ns/1ps
module prot_reg #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value
);
    typedef struct packed {
        logic [DATA_W-1:0] val;
    } preg_t;

    preg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit) begin
            r_d.val = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.val <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign value = r_q.val;

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (value == $past(wdata))); // R3
    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(value)); // R4
endmodule

// File: rtl/prot_unlock_regs.sv
`timescale 1ns/1ps
module prot_unlock_regs
    import prot_pkg::*;
#(
    parameter logic [7:0] RST_A = 8'h03,
    parameter logic [7:0] RST_B = 8'hA5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       lock,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b
);
    typedef struct packed {
        logic err;
    } stat_t;

    stat_t st_d, st_q;
    logic  armed;
    logic  prot_wr;
    logic  [DATA_W-1:0] pval [NUM_PROT];

    prot_arm u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .lock  (lock),
        .armed (armed)
    );

    for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
        localparam logic [DATA_W-1:0] RV   = (g == 0) ? RST_A : RST_B;
        localparam logic [ADDR_W-1:0] MYAD = ADR_BASE + ADDR_W'(g);
        prot_reg #(.DATA_W(DATA_W), .RST_VAL(RV)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (wr_en && armed && (addr == MYAD)),
            .wdata  (wdata),
            .value  (pval[g])
        );
    end

    assign prot_wr = wr_en && is_prot(addr);
    assign ctrl_a  = pval[0];
    assign ctrl_b  = pval[1];

    always_comb begin
        st_d = st_q;
        if (prot_wr && !armed) begin
            st_d.err = 1'b1;
        end else if (wr_en && addr == ADR_STAT && !wdata[0]) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADR_STAT) begin
                rdata = {7'd0, st_q.err};
            end else if (is_prot(addr)) begin
                rdata = pval[addr - ADR_BASE];
            end
        end
    end

    AST_ERR_ON_BAD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && !armed) |=> rdata_err_set()); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !(wr_en && addr == ADR_STAT && !wdata[0])) |=> st_q.err); // R8
    AST_GOOD_WR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_wr && armed && !st_q.err) |=> !st_q.err); // R3

    always_comb begin
        if (rst_n && rd_en && addr == ADR_CMD) begin
            AST_CMD_READS_ZERO: assert (rdata == 8'h00); // R2
        end
    end

    function automatic logic rdata_err_set();
        return st_q.err;
    endfunction
endmodule

// File: tb/test_prot_unlock_regs.sv
`timescale 1ns/1ps
module test_prot_unlock_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       lock = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, ctrl_a, ctrl_b;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    localparam logic [1:0] CMD = 2'd0, PA = 2'd1, PB = 2'd2, ST = 2'd3;

    always #10 clk = ~clk;

    prot_unlock_regs i_prot_unlock_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .lock(lock), .wdata(wdata), .rdata(rdata), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    // monitor: compares each read against the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read, actual %02h expected none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s addr %0d actual %02h expected %02h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic acc(input logic w, input logic r, input logic l,
                       input logic [1:0] a, input logic [7:0] d);
        wr_en = w; rd_en = r; lock = l; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; lock = 1'b0; wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        acc(1'b1, 1'b0, 1'b0, a, d);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        acc(1'b0, 1'b1, 1'b0, a, 8'h00);
    endtask

    task automatic lrd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        acc(1'b0, 1'b1, 1'b1, a, 8'h00);
    endtask

    task automatic lwr(input logic [1:0] a, input logic [7:0] d);
        acc(1'b1, 1'b0, 1'b1, a, d);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", t, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(ctrl_a, 8'h03, "R1 ctrl_a reset");
        chk(ctrl_b, 8'hA5, "R1 ctrl_b reset");
        rd(PA, 8'h03, "R1 read A");
        rd(PB, 8'hA5, "R1 read B");
        rd(ST, 8'h00, "R1 status");
        // R1/R4 not armed after reset
        wr(PA, 8'h11);
        rd(PA, 8'h03, "R4 unarmed write dropped");
        rd(ST, 8'h01, "R4 error set");
        wr(ST, 8'h00);
        rd(ST, 8'h00, "R8 clear with bit0=0");
        wr(ST, 8'h01);
        rd(ST, 8'h00, "R8 write 1 has no effect");
        // R2/R3 unlock with arbitrary data
        wr(CMD, 8'h00); wr(PA, 8'h5C);
        rd(PA, 8'h5C, "R3 commit A");
        chk(ctrl_a, 8'h5C, "R3 ctrl_a");
        wr(CMD, 8'hFF); wr(PB, 8'h3E);
        rd(PB, 8'h3E, "R3 commit B");
        chk(ctrl_b, 8'h3E, "R3 ctrl_b");
        rd(ST, 8'h00, "R3 no error");
        rd(CMD, 8'h00, "R2 command reads zero");
        // R10 window used once
        wr(CMD, 8'h5A); wr(PA, 8'h77); wr(PA, 8'h88);
        rd(PA, 8'h77, "R10 second write dropped");
        rd(ST, 8'h01, "R10 error");
        wr(ST, 8'hFE);
        rd(ST, 8'h00, "R8 clear with FE");
        // R5 intervening accesses
        wr(CMD, 8'h01); rd(ST, 8'h00, "R5 status read"); wr(PB, 8'h12);
        rd(PB, 8'h3E, "R5 dropped after status read");
        rd(ST, 8'h01, "R5 error after status read");
        wr(ST, 8'h00);
        wr(CMD, 8'h02); wr(ST, 8'h00); wr(PA, 8'h44);
        rd(PA, 8'h77, "R5 dropped after status write");
        rd(ST, 8'h01, "R5 error after status write");
        wr(ST, 8'h00);
        wr(CMD, 8'h03); rd(CMD, 8'h00, "R5 command read"); wr(PB, 8'h21);
        rd(PB, 8'h3E, "R5 dropped after command read");
        wr(ST, 8'h00);
        // R6 protected reads keep the window
        wr(CMD, 8'h04); rd(PA, 8'h77, "R6 read A"); rd(PB, 8'h3E, "R6 read B");
        wr(PA, 8'h66);
        rd(PA, 8'h66, "R6 commit after reads");
        rd(ST, 8'h00, "R6 no error");
        // R7 locked read-modify-write
        wr(CMD, 8'h05); lrd(ST, 8'h00, "R7 locked status read"); lwr(PA, 8'h67);
        rd(PA, 8'h67, "R7 locked write commits");
        lrd(PB, 8'h3E, "R7 locked read unarmed"); lwr(PB, 8'h3F);
        rd(PB, 8'h3E, "R7 unarmed locked write dropped");
        rd(ST, 8'h01, "R7 error");
        // R8 sticky across other traffic
        wr(CMD, 8'h06); rd(PA, 8'h67, "R8 read A"); wr(ST, 8'h01);
        rd(ST, 8'h01, "R8 still set");
        wr(ST, 8'h00);
        rd(ST, 8'h00, "R8 cleared");
        // R9 double command
        wr(CMD, 8'h07); wr(CMD, 8'h08); wr(PB, 8'h9A);
        rd(PB, 8'h9A, "R9 commit after rearm");
        chk(ctrl_b, 8'h9A, "R9 ctrl_b");
        rd(ST, 8'h00, "R9 no error");
        @(posedge clk); #1;
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard left %0d, expected 0", exp_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired, actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule